// File: doc/BRIEF.md
# Precision DAC Serial Register Slave

This block is the digital front end of a precision voltage-output converter. A host sends 24-bit words over a four-wire serial link made of a chip select, a clock, a data-in line and a data-out line. Each word carries a direction flag, a three-bit register selector and twenty data bits. The block keeps four registers: the pending output code, a mode word, a fallback code and a command word that can only be written. It drives the code the converter is showing and the mode bits that set the analog stage. The mode bits are the amplifier power-down, the ground clamp, the high-impedance state, offset-binary coding and a four-bit trim field.

All serial pins and the active-low `load_n` pin are sampled by the block's own clock. The link clock must therefore run at a quarter of the system clock or slower. A frame is acted on only when chip select rises after exactly 24 falling link-clock edges. A read request is answered during the next frame, most significant bit first. The code resolution is a parameter, either 18 or 20 bits. An 18-bit code sits in data bits 19:2 and the two lowest data bits are ignored.

Top module: `dacspi_slave`

## Requirements
- R1: After reset, `dac_code` is 0, `amp_off`, `gnd_clamp` and `dac_hiz` are 1, `offset_bin` is 0, `lin_trim` is 0 and `spi_miso_en` is 1.
- R2: `spi_mosi` is sampled on each falling edge of `spi_clk` while `spi_cs_n` is low, most significant bit first. Bit 23 is the direction flag (1 = read, 0 = write), bits 22:20 select the register (001 code, 010 mode, 011 fallback code, 100 command) and bits 19:0 are data.
- R3: A frame with fewer or more than 24 falling clock edges changes no register and no output.
- R4: A write to register 010 sets `amp_off` from data bit 1, `gnd_clamp` from bit 2, `dac_hiz` from bit 3, `offset_bin` from bit 4 and the output-disable bit from bit 5. `lin_trim` takes bits 9:6.
- R5: A write to register 001 stores data bits 19:(20-CODE_BITS) as the pending code. `dac_code` takes the new value at once only if `load_n` is low when the frame ends. Otherwise `dac_code` holds its value.
- R6: A falling edge on `load_n` copies the pending code to `dac_code`.
- R7: A write to register 100 with data bit 0 set copies the pending code to `dac_code`.
- R8: A write to register 011 stores the fallback code, in the same field as R5. A write to register 100 with data bit 1 set copies the fallback code into both the pending code and `dac_code`, and this takes priority over bit 0.
- R9: A write to register 100 with data bit 2 set returns every register and output to its R1 value, and this takes priority over bits 1 and 0.
- R10: The frame after an accepted read carries bit 23 = 1, the selected register in bits 22:20 and its contents in bits 19:0 on `spi_miso`. Codes are returned in their R5 field with the unused low bits at 0. The mode word is returned in bits 9:1. Any other selector returns zero data. The frame after an accepted write carries all zeros.
- R11: When the output-disable mode bit is 1, `spi_miso_en` is 0.
- R12: Read frames change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_clk | input | 1 | Serial link clock |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_en | output | 1 | Drive enable for `spi_miso` (0 = high impedance) |
| load_n | input | 1 | Active-low output update pin |
| dac_code | output | CODE_BITS | Code applied to the converter |
| amp_off | output | 1 | Output amplifier powered down |
| gnd_clamp | output | 1 | Output clamped to ground |
| dac_hiz | output | 1 | Converter output in high impedance |
| offset_bin | output | 1 | 1 = offset binary coding, 0 = twos complement |
| lin_trim | output | 4 | Linearity trim selection |

## Verification
The bench builds the block with `CODE_BITS = 18` and two synchronizer stages. The 18-bit width places the code above two ignored data bits, so the bench can show that the don't-care bits are dropped on write and read back as zero. The two-stage setting keeps the sampling delay short enough for a link clock at one twelfth of the system clock. With that ratio, frames of 23 and 25 edges and the response to a read in the following frame can be checked bit by bit.

// File: rtl/dacspi_pkg.sv
package dacspi_pkg;

   localparam int FRAME_W = 24;
   localparam int DATA_W  = 20;
   localparam int SEL_W   = 3;

   localparam logic [SEL_W-1:0] SEL_CODE  = 3'b001;
   localparam logic [SEL_W-1:0] SEL_MODE  = 3'b010;
   localparam logic [SEL_W-1:0] SEL_FALLB = 3'b011;
   localparam logic [SEL_W-1:0] SEL_CMD   = 3'b100;

   localparam int CMD_LOAD_BIT  = 0;
   localparam int CMD_FALLB_BIT = 1;
   localparam int CMD_RESET_BIT = 2;

   // mode word, packed in the order of data bits 9:1
   typedef struct packed {
      logic [3:0] lin_trim;
      logic       miso_off;
      logic       offset_bin;
      logic       dac_hiz;
      logic       gnd_clamp;
      logic       amp_off;
   } mode_t;

   localparam int MODE_W = $bits(mode_t);

   localparam mode_t MODE_RST = '{lin_trim: 4'h0, miso_off: 1'b0, offset_bin: 1'b0,
                                  dac_hiz: 1'b1, gnd_clamp: 1'b1, amp_off: 1'b1};

endpackage

// File: rtl/dacspi_sync.sv
module dacspi_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dacspi_frame.sv
module dacspi_frame
   import dacspi_pkg::*;
#(
   parameter int FW = FRAME_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n_s,
   input  logic          sclk_s,
   input  logic          mosi_s,
   input  logic [FW-1:0] rsp_word,
   output logic          frame_ok,
   output logic [FW-1:0] frame_word,
   output logic          miso
);

   localparam int CNT_W   = $clog2(FW + 2);
   localparam int CNT_TOP = FW + 1;

   logic             cs_q;
   logic             sclk_q;
   logic [CNT_W-1:0] edge_cnt;
   logic [FW-1:0]    rx_sh;
   logic [FW-1:0]    tx_sh;
   logic             cs_fall;
   logic             cs_rise;
   logic             sclk_fall;

   assign cs_fall   = cs_q & ~cs_n_s;
   assign cs_rise   = ~cs_q & cs_n_s;
   assign sclk_fall = sclk_q & ~sclk_s & ~cs_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         sclk_q <= 1'b0;
      end else begin
         cs_q   <= cs_n_s;
         sclk_q <= sclk_s;
      end
   end

   // falling-edge counter, saturating one above a full frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
      end else if (cs_fall) begin
         edge_cnt <= '0;
      end else if (sclk_fall && edge_cnt != CNT_W'(CNT_TOP)) begin
         edge_cnt <= edge_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh <= '0;
      end else if (sclk_fall) begin
         rx_sh <= {rx_sh[FW-2:0], mosi_s};
      end
   end

   // response word: loaded at frame start, advanced after each host sample
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
      end else if (cs_fall) begin
         tx_sh <= rsp_word;
      end else if (sclk_fall) begin
         tx_sh <= {tx_sh[FW-2:0], 1'b0};
      end
   end

   assign miso = tx_sh[FW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_ok   <= 1'b0;
         frame_word <= '0;
      end else begin
         frame_ok <= cs_rise && (edge_cnt == CNT_W'(FW));
         if (cs_rise) frame_word <= rx_sh;
      end
   end

endmodule

// File: rtl/dacspi_regs.sv
module dacspi_regs
   import dacspi_pkg::*;
#(
   parameter int CODE_BITS = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_ok,
   input  logic [FRAME_W-1:0]   frame_word,
   input  logic                 load_low,
   input  logic                 load_fall,
   output logic [CODE_BITS-1:0] code_out,
   output mode_t                mode_q,
   output logic [CODE_BITS-1:0] fallb_q,
   output logic [FRAME_W-1:0]   rsp_word
);

   localparam int PAD = DATA_W - CODE_BITS;

   logic                 is_read;
   logic [SEL_W-1:0]     sel;
   logic [DATA_W-1:0]    data;
   logic [CODE_BITS-1:0] new_code;
   logic [CODE_BITS-1:0] pend_q;
   logic [DATA_W-1:0]    pend_field;
   logic [DATA_W-1:0]    fallb_field;
   logic [DATA_W-1:0]    rd_data;

   assign is_read  = frame_word[FRAME_W-1];
   assign sel      = frame_word[FRAME_W-2 -: SEL_W];
   assign data     = frame_word[DATA_W-1:0];
   assign new_code = data[DATA_W-1 -: CODE_BITS];

   // code placement in the data field depends on the resolution
   if (PAD == 0) begin : g_full
      assign pend_field  = pend_q;
      assign fallb_field = fallb_q;
   end else begin : g_padded
      assign pend_field  = {pend_q,  {PAD{1'b0}}};
      assign fallb_field = {fallb_q, {PAD{1'b0}}};
   end

   always_comb begin
      rd_data = '0;
      case (sel)
         SEL_CODE:  rd_data = pend_field;
         SEL_MODE:  rd_data[MODE_W:1] = mode_q;
         SEL_FALLB: rd_data = fallb_field;
         default:   rd_data = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= '0;
         code_out <= '0;
         fallb_q  <= '0;
         mode_q   <= MODE_RST;
         rsp_word <= '0;
      end else begin
         if (load_fall) code_out <= pend_q;
         if (frame_ok) begin
            rsp_word <= is_read ? {1'b1, sel, rd_data} : '0;
            if (!is_read) begin
               case (sel)
                  SEL_CODE: begin
                     pend_q <= new_code;
                     if (load_low) code_out <= new_code;
                  end
                  SEL_MODE:  mode_q  <= mode_t'(data[MODE_W:1]);
                  SEL_FALLB: fallb_q <= new_code;
                  SEL_CMD: begin
                     if (data[CMD_RESET_BIT]) begin
                        pend_q   <= '0;
                        code_out <= '0;
                        fallb_q  <= '0;
                        mode_q   <= MODE_RST;
                     end else if (data[CMD_FALLB_BIT]) begin
                        pend_q   <= fallb_q;
                        code_out <= fallb_q;
                     end else if (data[CMD_LOAD_BIT]) begin
                        code_out <= pend_q;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/dacspi_slave.sv
module dacspi_slave
   import dacspi_pkg::*;
#(
   parameter int CODE_BITS   = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 spi_cs_n,
   input  logic                 spi_clk,
   input  logic                 spi_mosi,
   output logic                 spi_miso,
   output logic                 spi_miso_en,
   input  logic                 load_n,
   output logic [CODE_BITS-1:0] dac_code,
   output logic                 amp_off,
   output logic                 gnd_clamp,
   output logic                 dac_hiz,
   output logic                 offset_bin,
   output logic [3:0]           lin_trim
);

   localparam int          PIN_W   = 4;
   localparam logic [PIN_W-1:0] PIN_IDLE = 4'b1001;

   if (CODE_BITS != 18 && CODE_BITS != 20) begin : g_bad_code
      $error("dacspi_slave: CODE_BITS must be 18 or 20");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dacspi_slave: SYNC_STAGES must be at least 2");
   end

   logic [PIN_W-1:0]     pins_s;
   logic                 cs_n_s;
   logic                 sclk_s;
   logic                 mosi_s;
   logic                 load_s;
   logic                 load_q;
   logic                 load_fall;
   logic                 frame_ok;
   logic [FRAME_W-1:0]   frame_word;
   logic [FRAME_W-1:0]   rsp_word;
   logic [CODE_BITS-1:0] fallb_q;
   mode_t                mode_q;

   dacspi_sync #(
      .W      (PIN_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(PIN_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({spi_cs_n, spi_clk, spi_mosi, load_n}),
      .q    (pins_s)
   );

   assign {cs_n_s, sclk_s, mosi_s, load_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_q <= 1'b1;
      else        load_q <= load_s;
   end

   assign load_fall = load_q & ~load_s;

   dacspi_frame #(
      .FW(FRAME_W)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_s    (cs_n_s),
      .sclk_s    (sclk_s),
      .mosi_s    (mosi_s),
      .rsp_word  (rsp_word),
      .frame_ok  (frame_ok),
      .frame_word(frame_word),
      .miso      (spi_miso)
   );

   dacspi_regs #(
      .CODE_BITS(CODE_BITS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_ok  (frame_ok),
      .frame_word(frame_word),
      .load_low  (~load_s),
      .load_fall (load_fall),
      .code_out  (dac_code),
      .mode_q    (mode_q),
      .fallb_q   (fallb_q),
      .rsp_word  (rsp_word)
   );

   assign amp_off     = mode_q.amp_off;
   assign gnd_clamp   = mode_q.gnd_clamp;
   assign dac_hiz     = mode_q.dac_hiz;
   assign offset_bin  = mode_q.offset_bin;
   assign lin_trim    = mode_q.lin_trim;
   assign spi_miso_en = ~mode_q.miso_off;

endmodule

// File: rtl/dacspi_slave_chk.sv
module dacspi_slave_chk #(
   parameter int CODE_BITS = 20
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 frame_ok,
   input logic [23:0]          frame_word,
   input logic                 load_fall,
   input logic [CODE_BITS-1:0] fallb_q,
   input logic [CODE_BITS-1:0] dac_code,
   input logic                 amp_off,
   input logic                 gnd_clamp,
   input logic                 dac_hiz,
   input logic                 offset_bin,
   input logic [3:0]           lin_trim,
   input logic                 spi_miso_en
);

   p_reset_state_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (dac_code == '0 && amp_off && gnd_clamp && dac_hiz &&
                        !offset_bin && lin_trim == 4'h0 && spi_miso_en));

   p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_ok && !load_fall) |=> $stable(dac_code));

   p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_ok |=> $stable({amp_off, gnd_clamp, dac_hiz, offset_bin, lin_trim, spi_miso_en}));

   p_cmd_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ok && frame_word[23:20] == 4'b0100 && frame_word[2])
      |=> (dac_code == '0 && amp_off && gnd_clamp && dac_hiz && !offset_bin &&
           lin_trim == 4'h0 && spi_miso_en));

   p_cmd_fallback_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ok && frame_word[23:20] == 4'b0100 && frame_word[1] && !frame_word[2])
      |=> (dac_code == $past(fallb_q)));

endmodule

bind dacspi_slave dacspi_slave_chk #(.CODE_BITS(CODE_BITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_ok   (frame_ok),
   .frame_word (frame_word),
   .load_fall  (load_fall),
   .fallb_q    (fallb_q),
   .dac_code   (dac_code),
   .amp_off    (amp_off),
   .gnd_clamp  (gnd_clamp),
   .dac_hiz    (dac_hiz),
   .offset_bin (offset_bin),
   .lin_trim   (lin_trim),
   .spi_miso_en(spi_miso_en)
);

// File: tb/dacspi_slave_tb.sv
module dacspi_slave_tb;

   localparam int CB   = 18;
   localparam int HALF = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          spi_cs_n = 1'b1;
   logic          spi_clk = 1'b0;
   logic          spi_mosi = 1'b0;
   logic          load_n = 1'b1;
   logic          spi_miso;
   logic          spi_miso_en;
   logic [CB-1:0] dac_code;
   logic          amp_off, gnd_clamp, dac_hiz, offset_bin;
   logic [3:0]    lin_trim;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   logic [23:0] exp_q[$];
   logic [23:0] got_q[$];
   string       tag_q[$];

   always #10ns clk = ~clk;

   dacspi_slave #(.CODE_BITS(CB), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_clk(spi_clk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_en(spi_miso_en),
      .load_n(load_n), .dac_code(dac_code), .amp_off(amp_off),
      .gnd_clamp(gnd_clamp), .dac_hiz(dac_hiz), .offset_bin(offset_bin),
      .lin_trim(lin_trim)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: sends a frame and queues the expected response for the monitor
   task automatic xfer(input logic [23:0] w, input int nbits,
                       input logic [23:0] exp_rsp, input string tag);
      logic [23:0] cap = '0;
      spi_cs_n = 1'b0;
      wait_clk(2 * HALF);
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = (i < 24) ? w[23-i] : 1'b0;
         spi_clk  = 1'b1;
         wait_clk(HALF);
         if (i < 24) cap[23-i] = spi_miso;
         spi_clk = 1'b0;
         wait_clk(HALF);
      end
      spi_cs_n = 1'b1;
      wait_clk(2 * HALF);
      if (nbits == 24) begin
         exp_q.push_back(exp_rsp);
         tag_q.push_back(tag);
         got_q.push_back(cap);
      end
   endtask

   task automatic mode_chk(input string tag, input logic [4:0] m, input logic [3:0] trim);
      chk(tag, {27'd0, amp_off, gnd_clamp, dac_hiz, offset_bin, spi_miso_en},
               {27'd0, m});
      chk(tag, {28'd0, lin_trim}, {28'd0, trim});
   endtask

   // monitor: pops expected responses as captured ones appear
   initial begin
      forever begin
         @(negedge clk);
         while (got_q.size() > 0 && exp_q.size() > 0) begin
            logic [23:0] g;
            logic [23:0] e;
            string       t;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {8'd0, g}, {8'd0, e});
         end
      end
   end

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      // R1 reset values
      chk("R1 code", {14'd0, dac_code}, 32'h0);
      mode_chk("R1 mode", 5'b11101, 4'h0);

      // R4: mode write, trim A, offset binary, clamp/hiz/amp cleared (R2 framing)
      xfer(24'h200290, 24, 24'h0, "R2 R10 write frame returns zero");
      mode_chk("R4 mode write", 5'b00011, 4'hA);

      // R5: code write with load_n high; low bits 1:0 ignored
      xfer(24'h1AAAAF, 24, 24'h0, "R10 after write");
      chk("R5 hold while load_n high", {14'd0, dac_code}, 32'h0);

      // R10/R12: read code, then mode
      xfer(24'h900000, 24, 24'h0, "R10 after write");
      xfer(24'hA00000, 24, 24'h9AAAAC, "R10 code readback low bits zero");
      chk("R12 read leaves code", {14'd0, dac_code}, 32'h0);
      mode_chk("R12 read leaves mode", 5'b00011, 4'hA);

      // R6: load_n falling edge
      load_n = 1'b0;
      wait_clk(6);
      chk("R6 load edge", {14'd0, dac_code}, 32'h2AAAB);

      // R5: code write while load_n low updates at once
      xfer(24'h148D14, 24, 24'hA00290, "R10 mode readback");
      chk("R5 immediate update", {14'd0, dac_code}, 32'h12345);
      load_n = 1'b1;
      wait_clk(6);

      // R8: fallback code write
      xfer(24'h3FFFFC, 24, 24'h0, "R10 after write");
      chk("R8 fallback write no output change", {14'd0, dac_code}, 32'h12345);

      // R3: short and long frames setting output-disable and new trim
      xfer(24'h2003F0, 23, 24'h0, "unused");
      mode_chk("R3 short frame dropped", 5'b00011, 4'hA);
      xfer(24'h2003F0, 25, 24'h0, "unused");
      mode_chk("R3 long frame dropped", 5'b00011, 4'hA);

      // R7: command load
      xfer(24'h103C3C, 24, 24'h0, "R3 R10 after dropped frames");
      chk("R5 hold before command load", {14'd0, dac_code}, 32'h12345);
      xfer(24'h400001, 24, 24'h0, "R10 after write");
      chk("R7 command load", {14'd0, dac_code}, 32'h00F0F);

      // R8: command fallback with load bit also set
      xfer(24'h400003, 24, 24'h0, "R10 after write");
      chk("R8 fallback to output", {14'd0, dac_code}, 32'h3FFFF);
      xfer(24'h900000, 24, 24'h0, "R10 after write");
      xfer(24'hB00000, 24, 24'h9FFFFC, "R8 pending code took fallback");

      // R11: output disable
      xfer(24'h2002B0, 24, 24'hBFFFFC, "R10 fallback readback");
      chk("R11 miso disabled", {31'd0, spi_miso_en}, 32'h0);

      // R9: command reset with fallback bit also set
      xfer(24'h400006, 24, 24'h0, "R10 after write");
      chk("R9 code reset", {14'd0, dac_code}, 32'h0);
      mode_chk("R9 mode reset", 5'b11101, 4'h0);

      // R10: command register reads back zero data
      xfer(24'hC00000, 24, 24'h0, "R9 R10 after reset");
      xfer(24'h100004, 24, 24'hC00000, "R10 command read zero data");
      chk("R9 fallback cleared", {14'd0, dac_code}, 32'h0);
      xfer(24'h400002, 24, 24'h0, "R10 after write");
      chk("R9 fallback reg was cleared", {14'd0, dac_code}, 32'h0);

      wait_clk(4);
      finish_run();
   end

endmodule